// File: doc/BRIEF.md
# Protected Memory Region Access Filter

This block sits on the path from the on-chip agents to the memory controller. It decides, for each memory transaction, whether the issuing agent may touch the addressed location. Eight programmable regions each carry an inclusive low and high bound with 1 KB granularity, a read-permission mask and a write-permission mask. Each mask holds one bit per agent identity. A region can be frozen by a lock bit that only a reset clears.

Requests arrive on a valid/ready stream. A request is accepted in any cycle where `req_valid` and `req_ready` are both high. The decision is registered, and only an allowed request is presented to memory on the following cycle. While memory holds `mem_ready` low, the filter holds its forwarded request stable and drops `req_ready`, so back-pressure reaches the requester. A denied request never reaches memory. It completes in the cycle after acceptance: a denied read returns all-ones data, and `viol` pulses high to ask the reset controller for a system reset. Completions on `rsp_valid` have no back-pressure. They are single-cycle and must be taken when offered.

Top module: `memguard_filter`

## Requirements
- R1: After reset, every region has zero low and high address fields and no lock. Every read mask reads 0xBFFFFFFF and every write mask reads 0xFFFFFFFF. `req_ready` is high, and `mem_valid`, `rsp_valid` and `viol` are low.
- R2: The configuration address is {region[2:0], reg[1:0]}, where reg 0 is the low bound, 1 the high bound, 2 the read mask and 3 the write mask. In both bound registers, bits 24:2 hold the address bits 32:10. Bit 31 of the low bound is the lock. All other bound bits read as zero.
- R3: A transaction matches a region when its address bits 32:10 lie between the low field and the high field, both inclusive. The region therefore covers from low×1 KB up to, but not including, (high+1)×1 KB.
- R4: The agent number (0..31) selects one bit of the write mask for writes and of the read mask for reads. A clear bit denies the access.
- R5: When several regions match, the access is allowed only if every matching region grants it.
- R6: A region whose low or high field is zero takes no part in the decision.
- R7: A denied write never raises `mem_valid`. It completes with `rsp_valid` one cycle after acceptance.
- R8: A denied read completes one cycle after acceptance with `rsp_data` = 0xFFFFFFFF. An allowed read returns `mem_rdata`.
- R9: `viol` is high for exactly the one cycle in which a denied access completes.
- R10: Writing 1 to bit 31 of a low bound locks that region. After that, configuration writes to any of its four registers have no effect until reset.
- R11: An allowed request appears on the memory port one cycle after acceptance. While `mem_ready` is low, the address and data stay stable and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 5 | Configuration write address {region, reg} |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_raddr | input | 5 | Configuration read address |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 33 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_agent | input | 5 | Agent identity, selects mask bit |
| req_wdata | input | 32 | Write data |
| mem_valid | output | 1 | Forwarded request valid |
| mem_ready | input | 1 | Memory accepts forwarded request |
| mem_addr | output | 33 | Forwarded address |
| mem_write | output | 1 | Forwarded direction |
| mem_wdata | output | 32 | Forwarded write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| rsp_valid | output | 1 | Completion strobe |
| rsp_data | output | 32 | Read data or all ones when denied |
| viol | output | 1 | Violation pulse requesting system reset |

## Verification
The bench probes both edges of a region: the last word of the final 1 KB block and the first word past it. A design that compares against the raw high bound, without the extra block, would allow or deny the wrong word there. Overlapping regions with opposite grants catch a design that stops at the first match. A half-programmed region catches one that treats any nonzero bound as active. After a lock, the bench rewrites the locked region and reads it back, then sends a transaction. A lock that does not stick would show up as changed readback or an allowed access. Holding `mem_ready` low exposes a filter that drops, alters or re-accepts a stalled request.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int REG_W   = 32;
  localparam int FIELD_W = 23;          // address bits 32:10
  localparam logic [REG_W-1:0] RD_ALL = 32'hBFFF_FFFF;
  localparam logic [REG_W-1:0] WR_ALL = 32'hFFFF_FFFF;

  typedef struct packed {
    logic               lock;
    logic [FIELD_W-1:0] lo;
    logic [FIELD_W-1:0] hi;
    logic [REG_W-1:0]   rmask;
    logic [REG_W-1:0]   wmask;
  } region_t;

  typedef enum logic [1:0] {
    SLOT_LO    = 2'd0,
    SLOT_HI    = 2'd1,
    SLOT_RMASK = 2'd2,
    SLOT_WMASK = 2'd3
  } slot_e;
endpackage

// File: rtl/mg_region_file.sv
module mg_region_file #(
  parameter int N_RGN = 8,
  localparam int IDX_W = $clog2(N_RGN),
  localparam int CA_W  = IDX_W + 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [CA_W-1:0]             waddr,
  input  logic [mg_pkg::REG_W-1:0]    wdata,
  input  logic [CA_W-1:0]             raddr,
  output logic [mg_pkg::REG_W-1:0]    rdata,
  output mg_pkg::region_t [N_RGN-1:0] rgn
);
  import mg_pkg::*;

  logic [IDX_W-1:0] wsel;
  logic [IDX_W-1:0] rsel;
  slot_e            wslot;
  slot_e            rslot;
  logic             unused_bits;

  assign wsel  = waddr[CA_W-1:2];
  assign wslot = slot_e'(waddr[1:0]);
  assign rsel  = raddr[CA_W-1:2];
  assign rslot = slot_e'(raddr[1:0]);
  assign unused_bits = ^{wdata[30:FIELD_W+2], wdata[1:0]};

  for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rgn[g].lock  <= 1'b0;
        rgn[g].lo    <= '0;
        rgn[g].hi    <= '0;
        rgn[g].rmask <= RD_ALL;
        rgn[g].wmask <= WR_ALL;
      end else if (we && wsel == IDX_W'(g) && !rgn[g].lock) begin
        case (wslot)
          SLOT_LO: begin
            rgn[g].lo   <= wdata[FIELD_W+1:2];
            rgn[g].lock <= wdata[REG_W-1];
          end
          SLOT_HI:    rgn[g].hi    <= wdata[FIELD_W+1:2];
          SLOT_RMASK: rgn[g].rmask <= wdata;
          default:    rgn[g].wmask <= wdata;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (rslot)
      SLOT_LO: begin
        rdata[FIELD_W+1:2] = rgn[rsel].lo;
        rdata[REG_W-1]     = rgn[rsel].lock;
      end
      SLOT_HI:    rdata[FIELD_W+1:2] = rgn[rsel].hi;
      SLOT_RMASK: rdata = rgn[rsel].rmask;
      default:    rdata = rgn[rsel].wmask;
    endcase
  end
endmodule

// File: rtl/mg_region_check.sv
module mg_region_check (
  input  mg_pkg::region_t              rgn,
  input  logic [mg_pkg::FIELD_W-1:0]   blk,
  input  logic                         is_write,
  input  logic [$clog2(mg_pkg::REG_W)-1:0] agent,
  output logic                         deny
);
  logic active;
  logic hit;
  logic granted;

  assign active  = (rgn.lo != '0) && (rgn.hi != '0);
  assign hit     = active && (blk >= rgn.lo) && (blk <= rgn.hi);
  assign granted = is_write ? rgn.wmask[agent] : rgn.rmask[agent];
  assign deny    = hit && !granted;
endmodule

// File: rtl/memguard_filter.sv
module memguard_filter #(
  parameter int N_RGN  = 8,
  parameter int ADDR_W = 33,
  parameter int DATA_W = 32,
  localparam int CA_W  = $clog2(N_RGN) + 2,
  localparam int AG_W  = $clog2(mg_pkg::REG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CA_W-1:0]   cfg_waddr,
  input  logic [31:0]       cfg_wdata,
  input  logic [CA_W-1:0]   cfg_raddr,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [AG_W-1:0]   req_agent,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              viol
);
  import mg_pkg::*;

  region_t [N_RGN-1:0] rgn;
  logic    [N_RGN-1:0] deny_vec;
  logic    [N_RGN-1:0] lock_vec;

  logic              stg_valid;
  logic              stg_ok;
  logic              stg_write;
  logic [ADDR_W-1:0] stg_addr;
  logic [DATA_W-1:0] stg_data;
  logic              drain;

  mg_region_file #(.N_RGN(N_RGN)) u_file (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .waddr (cfg_waddr),
    .wdata (cfg_wdata),
    .raddr (cfg_raddr),
    .rdata (cfg_rdata),
    .rgn   (rgn)
  );

  for (genvar g = 0; g < N_RGN; g++) begin : g_chk
    mg_region_check u_chk (
      .rgn      (rgn[g]),
      .blk      (req_addr[ADDR_W-1:ADDR_W-FIELD_W]),
      .is_write (req_write),
      .agent    (req_agent),
      .deny     (deny_vec[g])
    );
    assign lock_vec[g] = rgn[g].lock;
  end

  assign drain     = stg_valid && (!stg_ok || mem_ready);
  assign req_ready = !stg_valid || drain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_valid <= 1'b0;
      stg_ok    <= 1'b0;
      stg_write <= 1'b0;
      stg_addr  <= '0;
      stg_data  <= '0;
    end else if (req_ready) begin
      stg_valid <= req_valid;
      if (req_valid) begin
        stg_ok    <= ~|deny_vec;
        stg_write <= req_write;
        stg_addr  <= req_addr;
        stg_data  <= req_wdata;
      end
    end
  end

  assign mem_valid = stg_valid && stg_ok;
  assign mem_addr  = stg_addr;
  assign mem_write = stg_write;
  assign mem_wdata = stg_data;
  assign rsp_valid = drain;
  assign rsp_data  = stg_ok ? mem_rdata : '1;
  assign viol      = stg_valid && !stg_ok;
endmodule

// File: rtl/mg_filter_chk.sv
module mg_filter_chk #(
  parameter int N_RGN  = 8,
  parameter int ADDR_W = 33,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              viol,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              stg_write,
  input logic              req_ready,
  input logic [N_RGN-1:0]  lock_vec
);
  AST_DENY_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> !mem_valid);                                                   // R7
  AST_DENY_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !stg_write) |-> (rsp_valid && rsp_data == '1));                // R8
  AST_VIOL_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> rsp_valid);                                                    // R9
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec)));            // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));        // R11
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> !req_ready);                              // R11
endmodule

bind memguard_filter mg_filter_chk #(.N_RGN(N_RGN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_filter_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .viol      (viol),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .stg_write (stg_write),
  .req_ready (req_ready),
  .lock_vec  (lock_vec)
);

// File: tb/sim_memguard_filter.sv
`timescale 1ns/1ps
module sim_memguard_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [4:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [32:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [4:0]  req_agent = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [32:0] mem_addr;
  logic        mem_write;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        viol;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;
  assign mem_rdata = mem_addr[31:0] ^ 32'hA5A5_0000;

  memguard_filter u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_agent(req_agent), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .viol(viol)
  );

  // addr, write, agent, expected allow
  localparam int NV = 16;
  localparam logic [32:0] V_ADDR [NV] = '{
    33'h4000, 33'h3FFC, 33'h4000, 33'h4000, 33'h4000, 33'h7FFC, 33'h6000, 33'h6000,
    33'h8000, 33'h8000, 33'h14000, 33'h10000, 33'h103FC, 33'h10400, 33'h9FFC, 33'hA000};
  localparam logic V_WR [NV] = '{0,0,0,1,1,0,1,0, 0,0,0,1,0,0,1,1};
  localparam logic [4:0] V_AG [NV] = '{0,5,1,1,0,0,1,1, 1,30,3,31,0,0,0,5};
  localparam logic V_OK [NV] = '{1,1,0,1,0,1,1,0, 1,0,1,0,0,1,1,1};

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int rg, input int slot, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = 5'(rg * 4 + slot); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input int rg, input int slot, output logic [31:0] v);
    cfg_raddr = 5'(rg * 4 + slot);
    #1 v = cfg_rdata;
  endtask

  // issue one request with mem_ready high; sample the cycle after acceptance
  task automatic do_req(input logic [32:0] a, input logic w, input logic [4:0] ag,
                        input logic [31:0] d, output logic rv, output logic mv,
                        output logic vi, output logic [31:0] rd, output logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_agent = ag; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    rv = rsp_valid; mv = mem_valid; vi = viol; rd = rsp_data; wd = mem_wdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic rv, mv, vi;
    logic [31:0] rd, wd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cfg_rd(5, 0, v); chk("R1 lo", {1'b0, v}, 33'h0);
    cfg_rd(5, 1, v); chk("R1 hi", {1'b0, v}, 33'h0);
    cfg_rd(5, 2, v); chk("R1 rmask", {1'b0, v}, 33'hBFFF_FFFF);
    cfg_rd(5, 3, v); chk("R1 wmask", {1'b0, v}, 33'hFFFF_FFFF);
    chk("R1 ready", {32'h0, req_ready}, 33'h1);
    chk("R1 idle", {30'h0, mem_valid, rsp_valid, viol}, 33'h0);

    // program regions (bound value = block number << 2)
    cfg_wr(0, 0, 32'h40);  cfg_wr(0, 1, 32'h7C);  cfg_wr(0, 2, 32'h1); cfg_wr(0, 3, 32'h2);
    cfg_wr(1, 0, 32'h60);  cfg_wr(1, 1, 32'h9C);  cfg_wr(1, 3, 32'h3);
    cfg_wr(2, 0, 32'h0);   cfg_wr(2, 1, 32'h140); cfg_wr(2, 2, 32'h0); cfg_wr(2, 3, 32'h0);
    cfg_wr(3, 0, 32'h100); cfg_wr(3, 1, 32'h100); cfg_wr(3, 2, 32'h0); cfg_wr(3, 3, 32'h0);

    // vector table: R3 bounds, R4 mask select, R5 overlap, R6 inactive, R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      do_req(V_ADDR[i], V_WR[i], V_AG[i], 32'hC0DE_0000 + 32'(i), rv, mv, vi, rd, wd);
      chk($sformatf("R7 R8 rsp vec%0d", i), {32'h0, rv}, 33'h1);
      chk($sformatf("R3 R4 R5 R6 allow vec%0d", i), {32'h0, mv}, {32'h0, V_OK[i]});
      chk($sformatf("R9 viol vec%0d", i), {32'h0, vi}, {32'h0, !V_OK[i]});
      if (!V_WR[i])
        chk($sformatf("R8 rdata vec%0d", i), {1'b0, rd},
            {1'b0, V_OK[i] ? (V_ADDR[i][31:0] ^ 32'hA5A5_0000) : 32'hFFFF_FFFF});
      else if (V_OK[i])
        chk($sformatf("R11 wdata vec%0d", i), {1'b0, wd}, {1'b0, 32'hC0DE_0000 + 32'(i)});
    end

    // R9 pulse width: one cycle, gone once drained
    do_req(33'h10000, 1'b0, 5'd2, 32'h0, rv, mv, vi, rd, wd);
    chk("R9 pulse", {32'h0, vi}, 33'h1);
    @(negedge clk);
    chk("R9 pulse end", {32'h0, viol}, 33'h0);

    // R2 field packing and reserved bits
    cfg_wr(6, 0, 32'h7FFF_FFFF);
    cfg_rd(6, 0, v); chk("R2 lo reserved", {1'b0, v}, 33'h01FF_FFFC);
    cfg_wr(6, 1, 32'hFFFF_FFFF);
    cfg_rd(6, 1, v); chk("R2 hi reserved", {1'b0, v}, 33'h01FF_FFFC);
    cfg_wr(6, 2, 32'h1234_5678);
    cfg_rd(6, 2, v); chk("R2 rmask", {1'b0, v}, 33'h1234_5678);

    // R10 lock
    cfg_wr(4, 0, 32'h180); cfg_wr(4, 1, 32'h180); cfg_wr(4, 2, 32'h0); cfg_wr(4, 3, 32'h0);
    cfg_wr(4, 0, 32'h8000_0180);
    cfg_wr(4, 0, 32'h0);
    cfg_rd(4, 0, v); chk("R10 lo locked", {1'b0, v}, 33'h8000_0180);
    cfg_wr(4, 2, 32'hFFFF_FFFF);
    cfg_rd(4, 2, v); chk("R10 rmask locked", {1'b0, v}, 33'h0);
    do_req(33'h18000, 1'b0, 5'd0, 32'h0, rv, mv, vi, rd, wd);
    chk("R10 still denies", {32'h0, vi}, 33'h1);

    // R11 back-pressure
    @(negedge clk);
    mem_ready = 1'b0;
    req_valid = 1'b1; req_addr = 33'h4000; req_write = 1'b0; req_agent = 5'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 fwd", {32'h0, mem_valid}, 33'h1);
    chk("R11 no rsp", {32'h0, rsp_valid}, 33'h0);
    chk("R11 ready low", {32'h0, req_ready}, 33'h0);
    @(negedge clk);
    chk("R11 addr held", mem_addr, 33'h4000);
    chk("R11 still valid", {32'h0, mem_valid}, 33'h1);
    mem_ready = 1'b1;
    #1;
    chk("R11 rsp", {32'h0, rsp_valid}, 33'h1);
    chk("R11 rdata", {1'b0, rsp_data}, {1'b0, 32'h4000 ^ 32'hA5A5_0000});
    @(negedge clk);
    chk("R11 drained", {31'h0, rsp_valid, req_ready}, 33'h1);

    // R1 R10 reset clears lock
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cfg_rd(4, 0, v); chk("R10 reset unlocks", {1'b0, v}, 33'h0);
    cfg_rd(4, 2, v); chk("R1 rmask default", {1'b0, v}, 33'hBFFF_FFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule